// File: doc/BRIEF.md
# Graphics Bit-Map Memory Access Sequencer

This block drives a dynamic memory that stores a graphics bit map of 16K words, each 16 bits wide, through an 8-bit address bus that carries the row half and then the column half of every access. It handles two kinds of work. A display fetch reads one word and places it in a 16-bit parallel-to-serial shifter, which supplies the graphics pixel stream one bit per shift enable. An update latches an address, new data and a bit mask, reads the stored word, merges it with the new data under the mask, and writes the result back. The memory is always updated by read-modify-write, never by a blind write.

The drawing engine sits upstream. It raises a level request for an update and holds it until the one-clock done pulse, and it raises a display request and holds it until the one-clock acknowledge. Updates are allowed only while the blanking input is high. An update requested during active video waits until blanking starts. Display fetches may run at any time the sequencer is idle and no update is eligible. The memory data pins are modelled as a separate read bus and write bus. The output-enable and write-enable strobes show which direction is active.

Top module: `gfx_dram_seq`

## Requirements
- R1: While reset is held and after it is released with no request, the row strobe, column strobe, write enable and output enable (all active low) are high, and the done pulse, display acknowledge and video output are 0.
- R2: Every access drops the row strobe with the row half (word address bits 7:0) on the address bus. The bus then switches to the column half (word address bits 13:8, zero-extended) while the row strobe stays low, and only then does the column strobe drop. The column strobe is never low while the row strobe is high.
- R3: The column strobe is issued only for word addresses below 0x4000. An access above that window performs a row-strobe-only cycle: memory is untouched, an update still gets its done pulse, and a display fetch loads all zeros into the shifter.
- R4: An update reads the stored word and writes back (old & ~mask) | (data & mask). A mask bit of 1 takes the new data bit and a mask bit of 0 keeps the old bit.
- R5: Output enable is low only during the read phase, while the column strobe is low, and never together with write enable. Write enable is low only while the column strobe is low.
- R6: An update starts only while blanking is high. An update request held during active video produces no memory cycle and no done pulse, and starts once blanking goes high.
- R7: The done pulse lasts exactly one clock and follows the write-back. The display acknowledge lasts one clock and appears when the shifter holds the fetched word.
- R8: The row strobe stays low for at least 2 clocks per access, and all strobes stay high for at least 2 clocks between accesses.
- R9: After a display fetch, the video output presents bit 15 of the fetched word first. Each clock with shift enable high advances one bit toward bit 0, and zeros follow the last bit.
- R10: If an update and a display fetch are both pending during blanking, the update is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_i | input | 1 | High during blanking; updates are allowed only then |
| upd_req_i | input | 1 | Update request, held until done |
| upd_addr_i | input | 16 | Update word address |
| upd_data_i | input | 16 | Update data |
| upd_mask_i | input | 16 | Update bit mask (1 = replace bit) |
| upd_done_o | output | 1 | One-clock pulse when the update has finished |
| disp_req_i | input | 1 | Display fetch request, held until acknowledge |
| disp_addr_i | input | 16 | Display fetch word address |
| disp_ack_o | output | 1 | One-clock pulse when the shifter has been loaded |
| shift_en_i | input | 1 | Advance the pixel shifter by one bit |
| video_o | output | 1 | Graphics pixel bit |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | 8 | Multiplexed row/column address |
| dram_dq_o | output | 16 | Write data to memory |
| dram_dq_i | input | 16 | Read data from memory |

## Verification
The bench uses a behavioural memory that captures the row and column halves at the strobe edges. A wrong row/column split or a column strobe issued too early therefore lands on the wrong word, and the read-back value shows it. Merges use partial masks, an all-zero mask and an all-one mask: a design that wrote the raw data or inverted the mask sense would corrupt the stored word. An update held through active video checks that no row strobe appears before blanking. An access just past the 16K window checks that a design which ignored the window does not overwrite the aliased word at 0x0000. Requests raised together during blanking confirm that the update is served before the display fetch.

// File: rtl/gfx_seq_pkg.sv
package gfx_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_RD,
      ST_MOD,
      ST_WR,
      ST_PRE
   } seq_st_e;

   function automatic logic [15:0] merge16(input logic [15:0] old_w,
                                           input logic [15:0] new_w,
                                           input logic [15:0] mask_w);
      return (old_w & ~mask_w) | (new_w & mask_w);
   endfunction

endpackage

// File: rtl/gfx_addr_mux.sv
module gfx_addr_mux #(
   parameter int ADDR_W    = 16,
   parameter int MEM_WORDS = 16384,
   parameter int MUX_W     = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              col_sel_i,
   output logic [MUX_W-1:0]  mux_o,
   output logic              in_win_o
);
   localparam int MEM_AW = $clog2(MEM_WORDS);
   localparam int COL_W  = MEM_AW - MUX_W;

   if (MEM_WORDS != (1 << MEM_AW)) begin : g_bad_words
      $error("MEM_WORDS must be a power of two");
   end
   if (COL_W < 1 || COL_W > MUX_W) begin : g_bad_split
      $error("column half must fit on the multiplexed bus");
   end
   if (ADDR_W < MEM_AW) begin : g_bad_aw
      $error("ADDR_W too narrow for memory");
   end

   logic [MUX_W-1:0] row_half;
   logic [MUX_W-1:0] col_half;

   assign row_half = addr_i[MUX_W-1:0];

   if (COL_W == MUX_W) begin : g_col_full
      assign col_half = addr_i[MEM_AW-1:MUX_W];
   end else begin : g_col_pad
      assign col_half = {{(MUX_W-COL_W){1'b0}}, addr_i[MEM_AW-1:MUX_W]};
   end

   if (ADDR_W > MEM_AW) begin : g_win_chk
      assign in_win_o = ~|addr_i[ADDR_W-1:MEM_AW];
   end else begin : g_win_all
      assign in_win_o = 1'b1;
   end

   assign mux_o = col_sel_i ? col_half : row_half;

endmodule

// File: rtl/gfx_seq_fsm.sv
module gfx_seq_fsm
   import gfx_seq_pkg::*;
#(
   parameter int PHASE_CYC = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    blank_i,
   input  logic    upd_req_i,
   input  logic    disp_req_i,
   input  logic    in_win_i,
   output seq_st_e st_o,
   output logic    ph_last_o,
   output logic    take_upd_o,
   output logic    take_disp_o,
   output logic    is_upd_o,
   output logic    done_o
);
   localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

   if (PHASE_CYC < 2) begin : g_bad_phase
      $error("PHASE_CYC must be at least 2");
   end

   seq_st_e    st_q, st_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic       is_upd_q;
   logic       done_q;
   logic       last;

   assign last        = (cnt_q == CNT_W'(PHASE_CYC-1));
   assign take_upd_o  = (st_q == ST_IDLE) && upd_req_i && blank_i;
   assign take_disp_o = (st_q == ST_IDLE) && disp_req_i && !take_upd_o;

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         ST_IDLE: st_nxt = ST_IDLE;
         ST_ROW:  st_nxt = ST_COL;
         ST_COL:  st_nxt = in_win_i ? ST_RD : ST_PRE;
         ST_RD:   st_nxt = is_upd_q ? ST_MOD : ST_PRE;
         ST_MOD:  st_nxt = ST_WR;
         ST_WR:   st_nxt = ST_PRE;
         ST_PRE:  st_nxt = ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         is_upd_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (st_q == ST_IDLE) begin
            cnt_q <= '0;
            if (take_upd_o || take_disp_o) begin
               st_q     <= ST_ROW;
               is_upd_q <= take_upd_o;
            end
         end else if (last) begin
            cnt_q <= '0;
            st_q  <= st_nxt;
            if (is_upd_q && ((st_q == ST_WR) || (st_q == ST_COL && !in_win_i)))
               done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign st_o      = st_q;
   assign ph_last_o = last && (st_q != ST_IDLE);
   assign is_upd_o  = is_upd_q;
   assign done_o    = done_q;

endmodule

// File: rtl/gfx_pixel_shifter.sv
module gfx_pixel_shifter #(
   parameter int DATA_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              shift_i,
   output logic              bit_o
);
   logic [DATA_W-1:0] sh_q;

   if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk) begin
         if (!rst_n)       sh_q <= '0;
         else if (load_i)  sh_q <= data_i;
         else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
      assign bit_o = sh_q[DATA_W-1];
   end else begin : g_lsb
      always_ff @(posedge clk) begin
         if (!rst_n)       sh_q <= '0;
         else if (load_i)  sh_q <= data_i;
         else if (shift_i) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
      end
      assign bit_o = sh_q[0];
   end

endmodule

// File: rtl/gfx_dram_seq.sv
module gfx_dram_seq
   import gfx_seq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int MEM_WORDS = 16384,
   parameter int MUX_W     = 8,
   parameter int PHASE_CYC = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blank_i,
   input  logic              upd_req_i,
   input  logic [ADDR_W-1:0] upd_addr_i,
   input  logic [DATA_W-1:0] upd_data_i,
   input  logic [DATA_W-1:0] upd_mask_i,
   output logic              upd_done_o,
   input  logic              disp_req_i,
   input  logic [ADDR_W-1:0] disp_addr_i,
   output logic              disp_ack_o,
   input  logic              shift_en_i,
   output logic              video_o,
   output logic              dram_ras_n_o,
   output logic              dram_cas_n_o,
   output logic              dram_we_n_o,
   output logic              dram_oe_n_o,
   output logic [MUX_W-1:0]  dram_addr_o,
   output logic [DATA_W-1:0] dram_dq_o,
   input  logic [DATA_W-1:0] dram_dq_i
);
   if (DATA_W != 16) begin : g_bad_dw
      $error("merge path is built for 16-bit words");
   end

   seq_st_e           st;
   logic              ph_last, take_upd, take_disp, cyc_is_upd;
   logic              cur_in_win;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, mask_q, rd_q, wr_q;
   logic              ack_q;
   logic              shift_load;
   logic [DATA_W-1:0] shift_val;

   gfx_seq_fsm #(.PHASE_CYC(PHASE_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .blank_i    (blank_i),
      .upd_req_i  (upd_req_i),
      .disp_req_i (disp_req_i),
      .in_win_i   (cur_in_win),
      .st_o       (st),
      .ph_last_o  (ph_last),
      .take_upd_o (take_upd),
      .take_disp_o(take_disp),
      .is_upd_o   (cyc_is_upd),
      .done_o     (upd_done_o)
   );

   gfx_addr_mux #(
      .ADDR_W   (ADDR_W),
      .MEM_WORDS(MEM_WORDS),
      .MUX_W    (MUX_W)
   ) u_mux (
      .addr_i   (addr_q),
      .col_sel_i(st != ST_ROW),
      .mux_o    (dram_addr_o),
      .in_win_o (cur_in_win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         mask_q <= '0;
         rd_q   <= '0;
         wr_q   <= '0;
         ack_q  <= 1'b0;
      end else begin
         ack_q <= shift_load;
         if (take_upd) begin
            addr_q <= upd_addr_i;
            data_q <= upd_data_i;
            mask_q <= upd_mask_i;
         end else if (take_disp) begin
            addr_q <= disp_addr_i;
         end
         if (st == ST_RD && ph_last)
            rd_q <= dram_dq_i;
         if (st == ST_MOD)
            wr_q <= merge16(rd_q, data_q, mask_q);
      end
   end

   assign shift_load = ph_last && !cyc_is_upd &&
                       ((st == ST_RD) || (st == ST_COL && !cur_in_win));
   assign shift_val  = (st == ST_RD) ? dram_dq_i : '0;

   gfx_pixel_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (shift_load),
      .data_i (shift_val),
      .shift_i(shift_en_i),
      .bit_o  (video_o)
   );

   assign dram_ras_n_o = !(st inside {ST_ROW, ST_COL, ST_RD, ST_MOD, ST_WR});
   assign dram_cas_n_o = !(st inside {ST_RD, ST_WR});
   assign dram_oe_n_o  = (st != ST_RD);
   assign dram_we_n_o  = (st != ST_WR);
   assign dram_dq_o    = wr_q;
   assign disp_ack_o   = ack_q;

endmodule

// File: rtl/gfx_dram_seq_chk.sv
module gfx_dram_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic blank_i,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic oe_n,
   input logic done,
   input logic win,
   input logic cyc_upd
);
   AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n); // R2
   AST_CAS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> win); // R3
   AST_OE_NOT_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> we_n); // R5
   AST_OE_WITH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !cas_n); // R5
   AST_WE_WITH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !cas_n); // R5
   AST_UPD_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && cyc_upd) |-> $past(blank_i)); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |=> !ras_n); // R8
   AST_RAS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |=> ras_n); // R8
endmodule

bind gfx_dram_seq gfx_dram_seq_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .blank_i(blank_i),
   .ras_n  (dram_ras_n_o),
   .cas_n  (dram_cas_n_o),
   .we_n   (dram_we_n_o),
   .oe_n   (dram_oe_n_o),
   .done   (upd_done_o),
   .win    (cur_in_win),
   .cyc_upd(cyc_is_upd)
);

// File: tb/gfx_dram_seq_test.sv
module gfx_dram_seq_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic blank = 1'b0;
   logic upd_req = 1'b0;
   logic [15:0] upd_addr = '0, upd_data = '0, upd_mask = '0;
   logic disp_req = 1'b0;
   logic [15:0] disp_addr = '0;
   logic shift_en = 1'b0;
   logic upd_done, disp_ack, video;
   logic ras_n, cas_n, we_n, oe_n;
   logic [7:0] dram_addr;
   logic [15:0] dq_o;
   logic [15:0] dq_i = 16'hDEAD;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gfx_dram_seq uut (
      .clk(clk), .rst_n(rst_n), .blank_i(blank),
      .upd_req_i(upd_req), .upd_addr_i(upd_addr), .upd_data_i(upd_data),
      .upd_mask_i(upd_mask), .upd_done_o(upd_done),
      .disp_req_i(disp_req), .disp_addr_i(disp_addr), .disp_ack_o(disp_ack),
      .shift_en_i(shift_en), .video_o(video),
      .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
      .dram_oe_n_o(oe_n), .dram_addr_o(dram_addr), .dram_dq_o(dq_o),
      .dram_dq_i(dq_i)
   );

   // behavioural memory and protocol monitor
   logic [15:0] mem [int];
   logic [7:0]  row_l = '0, col_l = '0;
   logic        prev_ras = 1'b1, prev_cas = 1'b1;
   int ras_falls = 0, cas_falls = 0;
   int low_len = 0, high_len = 10;
   int viol_r2 = 0, viol_r5 = 0, viol_r8 = 0;

   function automatic int word_of(input logic [7:0] r, input logic [7:0] c);
      return int'({c[5:0], r});
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (!ras_n && prev_ras) begin
            row_l = dram_addr;
            ras_falls++;
            if (high_len < 2) viol_r8++;
            low_len = 0;
         end
         if (ras_n && !prev_ras) begin
            if (low_len < 2) viol_r8++;
            high_len = 0;
         end
         if (!cas_n && prev_cas) begin
            col_l = dram_addr;
            cas_falls++;
         end
         if (!cas_n && ras_n) viol_r2++;
         if (!oe_n && (!we_n || cas_n)) viol_r5++;
         if (!we_n && cas_n) viol_r5++;
         if (!cas_n && !we_n) mem[word_of(row_l, col_l)] = dq_o;
         dq_i = (!cas_n && !oe_n) ? (mem.exists(word_of(row_l, col_l)) ?
                 mem[word_of(row_l, col_l)] : 16'h0000) : 16'hDEAD;
         if (!ras_n) low_len++; else high_len++;
         prev_ras = ras_n;
         prev_cas = cas_n;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] rd_mem(input int a);
      return mem.exists(a) ? mem[a] : 16'h0000;
   endfunction

   task automatic run_update(input logic [15:0] a, input logic [15:0] d,
                             input logic [15:0] m, input string req);
      int n = 0;
      int pulses = 0;
      upd_addr = a; upd_data = d; upd_mask = m; upd_req = 1'b1;
      while (!upd_done && n < 500) begin @(negedge clk); n++; end
      check(upd_done, req, {31'd0, upd_done}, 32'd1);
      upd_req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (upd_done) pulses++;
      end
      check(pulses == 0, "R7 done width", pulses, 0);
   endtask

   task automatic run_display(input logic [15:0] a, output logic [15:0] got);
      int n = 0;
      disp_addr = a; disp_req = 1'b1;
      while (!disp_ack && n < 500) begin @(negedge clk); n++; end
      check(disp_ack, "R7 display ack", {31'd0, disp_ack}, 32'd1);
      disp_req = 1'b0;
      got = '0;
      for (int i = 0; i < 16; i++) begin
         got = {got[14:0], video};
         shift_en = 1'b1;
         @(negedge clk);
         shift_en = 1'b0;
      end
   endtask

   task automatic t_reset();
      check({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
      check({upd_done, disp_ack, video} == 3'b000, "R1 outputs", {upd_done, disp_ack, video}, 0);
   endtask

   task automatic t_merge();
      blank = 1'b1;
      mem[16'h1234] = 16'hF0F0;
      run_update(16'h1234, 16'h1357, 16'h0FF0, "R4 partial merge");
      check(rd_mem(16'h1234) == 16'hF350, "R4 partial merge", rd_mem(16'h1234), 16'hF350);
      mem[16'h3FFF] = 16'hABCD;
      run_update(16'h3FFF, 16'h5555, 16'h0000, "R4 zero mask");
      check(rd_mem(16'h3FFF) == 16'hABCD, "R4 zero mask keeps word", rd_mem(16'h3FFF), 16'hABCD);
      mem[16'h0001] = 16'h0000;
      run_update(16'h0001, 16'h5A5A, 16'hFFFF, "R4 full mask");
      check(rd_mem(16'h0001) == 16'h5A5A, "R4 full mask", rd_mem(16'h0001), 16'h5A5A);
      check(rd_mem(16'h0000) == 16'h0000, "R2 neighbour untouched", rd_mem(16'h0000), 0);
   endtask

   task automatic t_hold();
      int f0;
      bit seen = 0;
      blank = 1'b0;
      mem[16'h0200] = 16'h1111;
      f0 = ras_falls;
      upd_addr = 16'h0200; upd_data = 16'h2222; upd_mask = 16'hFFFF; upd_req = 1'b1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (upd_done) seen = 1;
      end
      check(ras_falls == f0, "R6 no cycle in active video", ras_falls - f0, 0);
      check(!seen, "R6 no done in active video", seen, 0);
      check(rd_mem(16'h0200) == 16'h1111, "R6 word unchanged", rd_mem(16'h0200), 16'h1111);
      blank = 1'b1;
      run_update(16'h0200, 16'h2222, 16'hFFFF, "R6 starts in blanking");
      check(rd_mem(16'h0200) == 16'h2222, "R6 write after blank", rd_mem(16'h0200), 16'h2222);
   endtask

   task automatic t_window();
      int c0, r0;
      logic [15:0] got;
      blank = 1'b1;
      mem[16'h0000] = 16'h7777;
      c0 = cas_falls; r0 = ras_falls;
      run_update(16'h4000, 16'h0000, 16'hFFFF, "R3 out-of-window done");
      check(cas_falls == c0, "R3 no CAS out of window", cas_falls - c0, 0);
      check(ras_falls == r0 + 1, "R3 RAS-only cycle", ras_falls - r0, 1);
      check(rd_mem(16'h0000) == 16'h7777, "R3 alias untouched", rd_mem(16'h0000), 16'h7777);
      blank = 1'b0;
      c0 = cas_falls;
      run_display(16'h8005, got);
      check(got == 16'h0000, "R3 display zeros", got, 0);
      check(cas_falls == c0, "R3 display no CAS", cas_falls - c0, 0);
   endtask

   task automatic t_display();
      logic [15:0] got;
      blank = 1'b0;
      mem[16'h2ABC] = 16'hA5C3;
      run_display(16'h2ABC, got);
      check(got == 16'hA5C3, "R9 pixel order", got, 16'hA5C3);
      check(video == 1'b0, "R9 zero fill", video, 0);
      mem[16'h00FF] = 16'h8001;
      run_display(16'h00FF, got);
      check(got == 16'h8001, "R9 second pattern", got, 16'h8001);
   endtask

   task automatic t_priority();
      int n = 0;
      bit upd_first;
      logic [15:0] got;
      blank = 1'b1;
      mem[16'h0777] = 16'h0000;
      mem[16'h0778] = 16'h3C3C;
      upd_addr = 16'h0777; upd_data = 16'h9999; upd_mask = 16'hFFFF; upd_req = 1'b1;
      disp_addr = 16'h0778; disp_req = 1'b1;
      while (!upd_done && !disp_ack && n < 500) begin @(negedge clk); n++; end
      upd_first = upd_done && !disp_ack;
      check(upd_first, "R10 update served first", upd_first, 1);
      upd_req = 1'b0;
      n = 0;
      while (!disp_ack && n < 500) begin @(negedge clk); n++; end
      disp_req = 1'b0;
      got = '0;
      for (int i = 0; i < 16; i++) begin
         got = {got[14:0], video};
         shift_en = 1'b1;
         @(negedge clk);
         shift_en = 1'b0;
      end
      check(got == 16'h3C3C, "R10 display follows", got, 16'h3C3C);
      check(rd_mem(16'h0777) == 16'h9999, "R10 update written", rd_mem(16'h0777), 16'h9999);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_merge();
      t_hold();
      t_window();
      t_display();
      t_priority();
      repeat (5) @(negedge clk);
      check(viol_r2 == 0, "R2 strobe order", viol_r2, 0);
      check(viol_r5 == 0, "R5 data direction", viol_r5, 0);
      check(viol_r8 == 0, "R8 strobe widths", viol_r8, 0);
      finish_run();
   end

endmodule